// File: doc/BRIEF.md
# Bus Cycle Wait-State Generator

This block runs the processor side of a memory bus cycle as a short sequence of clock states. Each cycle has an address phase (T1), a strobe phase (T2), zero or more inserted wait states (TW) and a data-capture phase (T3). The wait states give slow memories and peripherals time to answer. How many are inserted depends on where the access lands. The upper address bits select one of several regions, and each region has its own wait count in a writable table.

A device that needs still more time can raise the external `wait_in` line. The cycle then stays in TW for as long as that line is high. A pending request is taken up straight after T3, so cycles can run back to back without an idle clock between them.

States: `S_IDLE`, `S_T1`, `S_T2`, `S_TW`, `S_T3`. Transitions:
- IDLE→T1 on a request.
- T1→T2 always.
- T2→T3 when the count is zero and `wait_in` is low; otherwise T2→TW.
- TW→TW while the count is not exhausted or `wait_in` is high.
- TW→T3 when the count is at one or below and `wait_in` is low.
- T3→T1 if a request is pending; otherwise T3→IDLE.

Top module: `bus_wait_seq`

## Requirements
- R1: While reset is held and after it is released with no request, the state is idle and `addr_strobe`, `rd_strobe`, `capture_strobe`, `cycle_done` and `busy` are all low.
- R2: A request in idle starts T1 on the next clock edge. In T1, `addr_strobe` is high and `bus_addr` shows the request address. `bus_addr` then stays unchanged through T2, TW and T3.
- R3: T1 is always followed by T2. `rd_strobe` is low in T1 and high in every clock of T2, TW and T3.
- R4: With `wait_in` low, a cycle lasts 3+N clocks from T1 to T3 inclusive, where N is the wait count of the selected region.
- R5: The region is address bits [15:14] (the top two bits): value 0 to 3 picks table entry 0 to 3. The four entries are independent 4-bit counts.
- R6: After reset every region's count is 15, the maximum, so every cycle lasts 18 clocks until the table is written.
- R7: `wait_in` is sampled on each edge that ends T2 or TW. The cycle moves to T3 only on an edge where the region count is used up and `wait_in` is low. If `wait_in` is high from T1 until the clock with index W (T1 counted as 0), the length is max(1+N, W)+2.
- R8: `capture_strobe` and `cycle_done` are high for exactly one clock per cycle, in T3.
- R9: If a request is present in T3, the next clock is T1 of the new cycle, showing the new address.
- R10: A table write (`cfg_we`, `cfg_region`, `cfg_wait`) made during a cycle does not change that cycle's length. The count is read on the edge that enters T1, and the new value applies from the next T1 on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req | input | 1 | Bus cycle request pending |
| req_addr | input | 16 | Address of the requested cycle |
| wait_in | input | 1 | External hold, high keeps the cycle in TW |
| cfg_we | input | 1 | Write strobe for the wait table |
| cfg_region | input | 2 | Table entry to write |
| cfg_wait | input | 4 | Wait count to store |
| bus_addr | output | 16 | Address driven onto the bus |
| addr_strobe | output | 1 | High in T1 |
| rd_strobe | output | 1 | High in T2, TW and T3 |
| capture_strobe | output | 1 | High in T3, data sampling point |
| cycle_done | output | 1 | High in T3, cycle completes |
| busy | output | 1 | High in any state but idle |

## Verification
The bench builds the block with its defaults: 16 address bits, 2 region bits and 4-bit counts. With these values every count from 0 to 15 can be swept in every one of the four regions, and the measured cycle length is compared with 3+N each time. Several `wait_in` hold lengths are run both shorter and longer than the programmed count, to reach the max(1+N, W) boundary. Further runs cover back-to-back cycles, writes to the table during a cycle, and the all-maximum table after reset.

// File: rtl/bws_pkg.sv
package bws_pkg;

    typedef enum logic [2:0] {
        S_IDLE = 3'd0,
        S_T1   = 3'd1,
        S_T2   = 3'd2,
        S_TW   = 3'd3,
        S_T3   = 3'd4
    } bus_state_e;

endpackage

// File: rtl/bws_wait_table.sv
module bws_wait_table #(
    parameter int IDX_W  = 2,
    parameter int WAIT_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [WAIT_W-1:0] wr_val,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [WAIT_W-1:0] rd_val
);
    localparam int                REGIONS  = 1 << IDX_W;
    localparam logic [WAIT_W-1:0] CNT_MAX  = '1;

    logic [WAIT_W-1:0] entry_q [REGIONS];

    for (genvar g = 0; g < REGIONS; g++) begin : g_entry
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                entry_q[g] <= CNT_MAX;
            end else if (wr_en && (wr_idx == IDX_W'(g))) begin
                entry_q[g] <= wr_val;
            end
        end
    end

    assign rd_val = entry_q[rd_idx];

endmodule

// File: rtl/bws_sequencer.sv
module bws_sequencer
    import bws_pkg::*;
#(
    parameter int WAIT_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req,
    input  logic              wait_in,
    input  logic [WAIT_W-1:0] load_val,
    output logic              launch,
    output logic              addr_strobe,
    output logic              rd_strobe,
    output logic              capture_strobe,
    output logic              cycle_done,
    output logic              busy
);
    localparam logic [WAIT_W-1:0] CNT_ZERO = '0;
    localparam logic [WAIT_W-1:0] CNT_ONE  = WAIT_W'(1);

    bus_state_e        state_q, state_d;
    logic [WAIT_W-1:0] cnt_q, cnt_d;

    // next state and countdown
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        launch  = 1'b0;
        unique case (state_q)
            S_IDLE: begin
                if (req) begin
                    state_d = S_T1;
                    launch  = 1'b1;
                    cnt_d   = load_val;
                end
            end
            S_T1: begin
                state_d = S_T2;
            end
            S_T2: begin
                if ((cnt_q == CNT_ZERO) && !wait_in) begin
                    state_d = S_T3;
                end else begin
                    state_d = S_TW;
                end
            end
            S_TW: begin
                if ((cnt_q <= CNT_ONE) && !wait_in) begin
                    state_d = S_T3;
                end
                if (cnt_q != CNT_ZERO) begin
                    cnt_d = cnt_q - CNT_ONE;
                end
            end
            S_T3: begin
                if (req) begin
                    state_d = S_T1;
                    launch  = 1'b1;
                    cnt_d   = load_val;
                end else begin
                    state_d = S_IDLE;
                end
            end
            default: begin
                state_d = S_IDLE;
            end
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
            cnt_q   <= CNT_ZERO;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    // outputs
    always_comb begin
        addr_strobe    = 1'b0;
        rd_strobe      = 1'b0;
        capture_strobe = 1'b0;
        cycle_done     = 1'b0;
        busy           = 1'b1;
        unique case (state_q)
            S_IDLE: busy = 1'b0;
            S_T1:   addr_strobe = 1'b1;
            S_T2:   rd_strobe = 1'b1;
            S_TW:   rd_strobe = 1'b1;
            S_T3: begin
                rd_strobe      = 1'b1;
                capture_strobe = 1'b1;
                cycle_done     = 1'b1;
            end
            default: busy = 1'b0;
        endcase
    end

    // R3: T1 always gives way to T2
    a_r3_t1_then_t2: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_T1) |=> (state_q == S_T2));

    // R7: a high hold line keeps the cycle in the wait state
    a_r7_wait_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (((state_q == S_T2) || (state_q == S_TW)) && wait_in) |=> (state_q == S_TW));

    // R4: an unexhausted count stays in TW and steps down by one
    a_r4_count_steps: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_q == S_TW) && (cnt_q > CNT_ONE)) |=>
        ((state_q == S_TW) && (cnt_q == $past(cnt_q) - CNT_ONE)));

    // R8: completion lasts a single clock
    a_r8_single_done: assert property (@(posedge clk) disable iff (!rst_n)
        cycle_done |=> !cycle_done);

    // R9: a request seen in T3 opens the next T1 at once
    a_r9_back_to_back: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_q == S_T3) && req) |=> addr_strobe);

endmodule

// File: rtl/bus_wait_seq.sv
module bus_wait_seq #(
    parameter int ADDR_W = 16,
    parameter int RGN_W  = 2,
    parameter int WAIT_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              wait_in,
    input  logic              cfg_we,
    input  logic [RGN_W-1:0]  cfg_region,
    input  logic [WAIT_W-1:0] cfg_wait,
    output logic [ADDR_W-1:0] bus_addr,
    output logic              addr_strobe,
    output logic              rd_strobe,
    output logic              capture_strobe,
    output logic              cycle_done,
    output logic              busy
);
    logic [RGN_W-1:0]  req_region;
    logic [WAIT_W-1:0] region_wait;
    logic              launch;

    assign req_region = req_addr[ADDR_W-1 -: RGN_W];

    bws_wait_table #(
        .IDX_W  (RGN_W),
        .WAIT_W (WAIT_W)
    ) u_table (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (cfg_we),
        .wr_idx (cfg_region),
        .wr_val (cfg_wait),
        .rd_idx (req_region),
        .rd_val (region_wait)
    );

    bws_sequencer #(
        .WAIT_W (WAIT_W)
    ) u_seq (
        .clk            (clk),
        .rst_n          (rst_n),
        .req            (req),
        .wait_in        (wait_in),
        .load_val       (region_wait),
        .launch         (launch),
        .addr_strobe    (addr_strobe),
        .rd_strobe      (rd_strobe),
        .capture_strobe (capture_strobe),
        .cycle_done     (cycle_done),
        .busy           (busy)
    );

    // address is latched on the edge that opens T1
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bus_addr <= '0;
        end else if (launch) begin
            bus_addr <= req_addr;
        end
    end

    // R2: the address holds for the whole cycle after T1
    a_r2_addr_stable: assert property (@(posedge clk) disable iff (!rst_n)
        rd_strobe |-> $stable(bus_addr));

    // R3: address and read strobes never overlap
    a_r3_strobes_apart: assert property (@(posedge clk) disable iff (!rst_n)
        !(addr_strobe && rd_strobe));

endmodule

// File: tb/sim_bus_wait_seq.sv
module sim_bus_wait_seq;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req = 1'b0;
    logic [15:0] req_addr = '0;
    logic        wait_in = 1'b0;
    logic        cfg_we = 1'b0;
    logic [1:0]  cfg_region = '0;
    logic [3:0]  cfg_wait = '0;
    logic [15:0] bus_addr;
    logic        addr_strobe, rd_strobe, capture_strobe, cycle_done, busy;

    int total = 0;
    int fails = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    bus_wait_seq u0 (
        .clk(clk), .rst_n(rst_n), .req(req), .req_addr(req_addr),
        .wait_in(wait_in), .cfg_we(cfg_we), .cfg_region(cfg_region),
        .cfg_wait(cfg_wait), .bus_addr(bus_addr), .addr_strobe(addr_strobe),
        .rd_strobe(rd_strobe), .capture_strobe(capture_strobe),
        .cycle_done(cycle_done), .busy(busy)
    );

    task automatic chk(input bit ok, input string rq, input int act, input int exp);
        total++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", rq, act, exp);
        end
    endtask

    task automatic write_cfg(input int rg, input int val);
        @(negedge clk);
        cfg_we = 1'b1; cfg_region = 2'(rg); cfg_wait = 4'(val);
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    // Runs one cycle from idle; w = hold index, expn = expected count.
    // Optional mid-cycle write at T2. keep = leave req high with next_a at T3.
    task automatic bus_cycle(input logic [15:0] a, input int w, input int expn,
                             input bit mw, input int mw_rg, input int mw_val,
                             input bit keep, input logic [15:0] next_a);
        int i;
        int exp_len;
        @(negedge clk);
        req = 1'b1; req_addr = a; wait_in = 1'b0;
        @(negedge clk);
        chk(addr_strobe == 1'b1, "R2 addr_strobe in T1", int'(addr_strobe), 1);
        chk(bus_addr == a, "R2 bus_addr in T1", int'(bus_addr), int'(a));
        chk(rd_strobe == 1'b0, "R3 rd_strobe low in T1", int'(rd_strobe), 0);
        req = 1'b0;
        wait_in = (0 < w);
        i = 0;
        while (1) begin
            i++;
            @(negedge clk);
            if (mw && i == 1) begin
                cfg_we = 1'b1; cfg_region = 2'(mw_rg); cfg_wait = 4'(mw_val);
            end else begin
                cfg_we = 1'b0;
            end
            if (rd_strobe !== 1'b1) begin
                chk(1'b0, "R3 rd_strobe high after T1", int'(rd_strobe), 1);
            end
            if (capture_strobe) break;
            if (i > 200) break;
            wait_in = (i < w);
        end
        cfg_we = 1'b0;
        wait_in = 1'b0;
        exp_len = ((1 + expn) > w ? (1 + expn) : w) + 2;
        if (w == 0) chk(i + 1 == exp_len, "R4 cycle length", i + 1, exp_len);
        else        chk(i + 1 == exp_len, "R7 cycle length with hold", i + 1, exp_len);
        chk(cycle_done == 1'b1, "R8 cycle_done in T3", int'(cycle_done), 1);
        chk(bus_addr == a, "R2 bus_addr held to T3", int'(bus_addr), int'(a));
        if (keep) begin
            req = 1'b1; req_addr = next_a;
        end
        @(negedge clk);
        chk(cycle_done == 1'b0, "R8 cycle_done one clock", int'(cycle_done), 0);
        if (keep) begin
            chk(addr_strobe == 1'b1, "R9 back-to-back T1", int'(addr_strobe), 1);
            chk(bus_addr == next_a, "R9 new address", int'(bus_addr), int'(next_a));
            req = 1'b0;
            i = 0;
            while (!capture_strobe && i < 200) begin
                @(negedge clk);
                i++;
            end
            @(negedge clk);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk({addr_strobe, rd_strobe, capture_strobe, cycle_done, busy} == 5'b0,
            "R1 outputs in reset", int'({addr_strobe, rd_strobe, capture_strobe, cycle_done, busy}), 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk(busy == 1'b0 && addr_strobe == 1'b0, "R1 idle after reset", int'(busy), 0);

        // R6: every region at maximum after reset
        for (int r = 0; r < 4; r++) begin
            bus_cycle({2'(r), 14'h0123}, 0, 15, 1'b0, 0, 0, 1'b0, 16'h0);
        end

        // R4/R5: sweep every count in every region
        for (int n = 0; n < 16; n++) begin
            for (int r = 0; r < 4; r++) write_cfg(r, (n + r * 5) % 16);
            for (int r = 0; r < 4; r++) begin
                bus_cycle({2'(r), 14'(n * 331 + r)}, 0, (n + r * 5) % 16,
                          1'b0, 0, 0, 1'b0, 16'h0);
            end
        end

        // R7: external hold shorter and longer than the count
        for (int n = 0; n < 16; n += 5) begin
            write_cfg(2, n);
            for (int w = 1; w < 12; w += 3) begin
                bus_cycle({2'd2, 14'h2AAA}, w, n, 1'b0, 0, 0, 1'b0, 16'h0);
            end
        end

        // R9: back-to-back, second cycle in region 1
        write_cfg(0, 1);
        write_cfg(1, 0);
        bus_cycle(16'h0042, 0, 1, 1'b0, 0, 0, 1'b1, 16'h4321);

        // R10: write to the active region mid-cycle, then the next cycle
        write_cfg(3, 4);
        bus_cycle(16'hC00F, 0, 4, 1'b1, 3, 9, 1'b0, 16'h0);
        bus_cycle(16'hC010, 0, 9, 1'b0, 0, 0, 1'b0, 16'h0);

        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", total - fails, total);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            total++;
            fails++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("%0d/%0d checks passed", total - fails, total);
            $finish;
        end
    end

endmodule